// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block models the write side of a small NOR-style flash array. Two requesters share it. The first is a read port that the cached instruction-fetch path uses to execute code in place. The second is a command port that firmware drives to program words and to erase regions. The array is held in internal storage, and every timing figure is counted in clock cycles.

Programming can only clear bits. Each stored word becomes the old word ANDed with the incoming word, and only an erase can bring bits back to 1. Both programs and erases move through the array one word per cycle.

At the end of each erase unit (a chunk of `CHUNK_WORDS` words, which stands for 4 KB), the sequencer checks a pending-interrupt input. If that input is set, it pauses until the interrupt has been serviced. A running operation can also be suspended. The suspend takes effect after a fixed latency. After a resume, further suspend requests are ignored for a short guard interval. While any operation is in flight, the read port is stalled.

Top module: `flash_pe_seq`

## Requirements
- R1: `cmd_op`=2'b10 (sector erase) sets all `CHUNK_WORDS` words of the chunk that holds `cmd_addr` to 32'hFFFF_FFFF. Words outside that chunk are untouched. `cmd_op`=2'b11 (chip erase) sets every word of the array to 32'hFFFF_FFFF.
- R2: `cmd_op`=2'b01 (program) with byte address `cmd_addr` and byte length `cmd_len` takes one word from `pdat` per cycle, and `pdat_take` marks each word taken. It stores the old value ANDed with that word at consecutive word addresses, so a bit that holds 0 reads 0 until it is erased.
- R3: A program whose `cmd_addr[1:0]` is not 0, or a command with `cmd_op`=2'b00, is refused. Refusal means `cmd_err` is high in the cycle after `cmd_valid` and no operation starts.
- R4: A program with `cmd_len` of 0, not a multiple of 4, or above `PAGE_BYTES` is refused in the same way.
- R5: Each active cycle completes exactly one word. In the cycle after the final word, `busy` is low and `done` pulses for one cycle. `irq_done` is set at the same moment and stays set until `irq_clr` is sampled high.
- R6: After the sequencer completes the last word of a chunk with words still left, and `irq_pend` is sampled high, it asserts `yielding`. It makes no progress until `irq_pend` is sampled low.
- R7: `rd_ready` equals `rd_en & rd_req & ~busy`. `rd_data` returns the stored word at word address `rd_addr`.
- R8: A command issued while `rd_en` is high is refused as in R3.
- R9: A command issued while `busy` is high is refused as in R3, and the running operation continues unchanged.
- R10: A `susp_req` sampled during a running or yielding operation makes `suspended` rise `SUSP_LAT` cycles later. Words keep completing until then. `suspended` holds until `resume_req`, and progress then continues from where it stopped.
- R11: A `susp_req` sampled within `RESUME_GAP` cycles after a resume is ignored.
- R12: After reset, the sequencer is idle, `irq_done` is low, and every word reads 32'hFFFF_FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read mode enable; blocks commands when set |
| rd_req | input | 1 | Read request |
| rd_addr | input | WA | Read word address |
| rd_ready | output | 1 | Read served this cycle |
| rd_data | output | 32 | Read word |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 01 program, 10 sector erase, 11 chip erase |
| cmd_addr | input | WA+2 | Command byte address |
| cmd_len | input | LEN_W | Program length in bytes |
| cmd_err | output | 1 | Command refused (one-cycle pulse) |
| pdat | input | 32 | Program data word |
| pdat_take | output | 1 | `pdat` consumed at this edge |
| irq_pend | input | 1 | Pending interrupt; pauses at chunk ends |
| susp_req | input | 1 | Suspend request |
| resume_req | input | 1 | Resume request |
| busy | output | 1 | Operation in flight |
| suspended | output | 1 | Operation suspended |
| yielding | output | 1 | Paused at a chunk end for an interrupt |
| done | output | 1 | Completion pulse |
| irq_done | output | 1 | Sticky completion interrupt |
| irq_clr | input | 1 | Clears `irq_done` |

## Verification
The bench builds the block with a 64-word array, 8-word chunks, a suspend latency of 6 and a resume guard of 3. With these values a full 256-byte page program covers the whole array and crosses every chunk boundary, so the yield check fires repeatedly. A chip erase finishes in 64 cycles. The short latency and guard make it practical to count the exact suspend delay and to place a request inside the guard window. Small chunks also let a single program straddle two chunks, so a sector erase can be shown to stop at its chunk edge.

// File: rtl/flash_pe_seq.sv
module flash_pe_seq #(
  parameter int DEPTH_WORDS = 256,
  parameter int CHUNK_WORDS = 16,
  parameter int PAGE_BYTES  = 256,
  parameter int SUSP_LAT    = 12,
  parameter int RESUME_GAP  = 4,
  parameter int LEN_W       = 10,
  localparam int WA = $clog2(DEPTH_WORDS),
  localparam int AW = WA + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             rd_req,
  input  logic [WA-1:0]    rd_addr,
  output logic             rd_ready,
  output logic [31:0]      rd_data,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [LEN_W-1:0] cmd_len,
  output logic             cmd_err,
  input  logic [31:0]      pdat,
  output logic             pdat_take,
  input  logic             irq_pend,
  input  logic             susp_req,
  input  logic             resume_req,
  output logic             busy,
  output logic             suspended,
  output logic             yielding,
  output logic             done,
  output logic             irq_done,
  input  logic             irq_clr
);
  localparam int CW    = $clog2(CHUNK_WORDS);
  localparam int LAT_W = $clog2(SUSP_LAT + 2);
  localparam int GAP_W = $clog2(RESUME_GAP + 2);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_YLD, S_SUS} st_t;

  st_t              st;
  logic [31:0]      mem [DEPTH_WORDS];
  logic [WA-1:0]    ptr;
  logic [WA:0]      rem;
  logic [LAT_W-1:0] lat;
  logic [GAP_W-1:0] gap;
  logic             prog_q, done_q, err_q, irq_q;

  wire active    = (st == S_RUN) || (st == S_YLD);
  wire lat_fire  = active && (lat == LAT_W'(1));
  wire step      = (st == S_RUN) && !lat_fire;
  wire last      = (rem == (WA+1)'(1));
  wire chunk_end = &ptr[CW-1:0];

  wire [WA-1:0] cmd_word = cmd_addr[AW-1:2];
  wire bad_len = (cmd_len == '0) || (cmd_len[1:0] != 2'b00) ||
                 (cmd_len > LEN_W'(PAGE_BYTES));
  wire bad_cmd = rd_en || (cmd_op == 2'b00) ||
                 ((cmd_op == 2'b01) && ((cmd_addr[1:0] != 2'b00) || bad_len));

  assign busy      = (st != S_IDLE);
  assign suspended = (st == S_SUS);
  assign yielding  = (st == S_YLD);
  assign done      = done_q;
  assign cmd_err   = err_q;
  assign irq_done  = irq_q;
  assign pdat_take = step && prog_q;
  assign rd_ready  = rd_en && rd_req && (st == S_IDLE);
  assign rd_data   = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH_WORDS; i++) mem[i] <= '1;
    end else if (step) begin
      mem[ptr] <= prog_q ? (mem[ptr] & pdat) : '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ptr    <= '0;
      rem    <= '0;
      lat    <= '0;
      gap    <= '0;
      prog_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= cmd_valid && (busy || bad_cmd);
      irq_q  <= (irq_q && !irq_clr) || (step && last);
      if (gap != '0) gap <= gap - 1'b1;
      if (active) begin
        if (lat != '0) lat <= lat - 1'b1;
        else if (susp_req && gap == '0) lat <= LAT_W'(SUSP_LAT);
      end
      case (st)
        S_IDLE: if (cmd_valid && !bad_cmd) begin
          st     <= S_RUN;
          prog_q <= (cmd_op == 2'b01);
          lat    <= '0;
          gap    <= '0;
          case (cmd_op)
            2'b01: begin
              ptr <= cmd_word;
              rem <= (WA+1)'(cmd_len >> 2);
            end
            2'b10: begin
              ptr <= {cmd_word[WA-1:CW], {CW{1'b0}}};
              rem <= (WA+1)'(CHUNK_WORDS);
            end
            default: begin
              ptr <= '0;
              rem <= (WA+1)'(DEPTH_WORDS);
            end
          endcase
        end
        S_RUN: begin
          if (lat_fire) st <= S_SUS;
          else begin
            ptr <= ptr + 1'b1;
            rem <= rem - 1'b1;
            if (last) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
              lat    <= '0;
            end else if (chunk_end && irq_pend) begin
              st <= S_YLD;
            end
          end
        end
        S_YLD: begin
          if (lat_fire) st <= S_SUS;
          else if (!irq_pend) st <= S_RUN;
        end
        default: begin
          if (resume_req) begin
            st  <= S_RUN;
            gap <= GAP_W'(RESUME_GAP);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/flash_pe_seq_chk.sv
module flash_pe_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic       rd_req,
  input logic       rd_ready,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic [1:0] cmd_lsb,
  input logic       cmd_err,
  input logic       busy,
  input logic       done,
  input logic       irq_done,
  input logic       irq_clr,
  input logic       irq_pend,
  input logic       resume_req,
  input logic       suspended,
  input logic       yielding,
  input logic       pdat_take
);
  assert_ready_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> (rd_en && rd_req && !busy));

  assert_rden_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && rd_en && !busy) |=> (cmd_err && !busy));

  assert_busy_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy) |=> cmd_err);

  assert_misaligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && !rd_en && cmd_op == 2'b01 && cmd_lsb != 2'b00) |=> (cmd_err && !busy));

  assert_done_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_done && !irq_clr) |=> irq_done);

  assert_held_no_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended || yielding) |-> !pdat_take);

  assert_susp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && !resume_req) |=> suspended);

  assert_yield_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (yielding && irq_pend) |=> (yielding || suspended));

  assert_pause_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({suspended, yielding}));
endmodule

bind flash_pe_seq flash_pe_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_req(rd_req), .rd_ready(rd_ready),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_lsb(cmd_addr[1:0]), .cmd_err(cmd_err),
  .busy(busy), .done(done), .irq_done(irq_done), .irq_clr(irq_clr), .irq_pend(irq_pend),
  .resume_req(resume_req), .suspended(suspended), .yielding(yielding), .pdat_take(pdat_take)
);

// File: tb/flash_pe_seq_bench.sv
module flash_pe_seq_bench;
  localparam int DW = 64, CH = 8, SL = 6, RG = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_en = 0, rd_req = 0, cmd_valid = 0, irq_pend = 0, susp_req = 0, resume_req = 0, irq_clr = 0;
  logic [5:0]  rd_addr = '0;
  logic [1:0]  cmd_op = '0;
  logic [7:0]  cmd_addr = '0;
  logic [9:0]  cmd_len = '0;
  logic [31:0] pdat, rd_data;
  logic rd_ready, cmd_err, pdat_take, busy, suspended, yielding, done, irq_done;

  logic [31:0] pbuf [64];
  int pidx = 0;
  assign pdat = pbuf[pidx & 63];

  always #5 clk = ~clk;

  flash_pe_seq #(.DEPTH_WORDS(DW), .CHUNK_WORDS(CH), .SUSP_LAT(SL), .RESUME_GAP(RG)) u_flash_pe_seq (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rd_data(rd_data), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_err(cmd_err), .pdat(pdat),
    .pdat_take(pdat_take), .irq_pend(irq_pend), .susp_req(susp_req), .resume_req(resume_req),
    .busy(busy), .suspended(suspended), .yielding(yielding), .done(done),
    .irq_done(irq_done), .irq_clr(irq_clr));

  int checks = 0, errors = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int mst = 0, mptr = 0, mleft = 0, mlat = 0, mgap = 0, g0 = 0;
  bit mprog = 0, mdone = 0, merr = 0, mirq = 0, took = 0, act = 0, fire = 0, stp = 0, bad = 0;
  logic [31:0] mm [DW];

  always @(posedge clk) begin
    if (!rst_n) begin
      mst = 0; mptr = 0; mleft = 0; mlat = 0; mgap = 0;
      mprog = 0; mdone = 0; merr = 0; mirq = 0; took = 0;
      for (int i = 0; i < DW; i++) mm[i] = 32'hFFFF_FFFF;
    end else begin
      act  = (mst == 1 || mst == 2);
      fire = act && mlat == 1;
      stp  = (mst == 1) && !fire;
      bad  = rd_en || cmd_op == 0 || (cmd_op == 1 && (cmd_addr[1:0] != 0 || cmd_len == 0 ||
             cmd_len > 256 || cmd_len % 4 != 0));
      merr = cmd_valid && (mst != 0 || bad);
      mirq = (mirq && !irq_clr) || (stp && mleft == 1);
      mdone = 0;
      if (stp) begin
        mm[mptr] = mprog ? (mm[mptr] & pdat) : 32'hFFFF_FFFF;
        if (mprog) took = 1;
      end
      g0 = mgap;
      if (mgap > 0) mgap--;
      if (act) begin
        if (mlat > 0) mlat--;
        else if (susp_req && g0 == 0) mlat = SL;
      end
      case (mst)
        0: if (cmd_valid && !bad) begin
          mst = 1; mprog = (cmd_op == 1); mlat = 0; mgap = 0;
          if (cmd_op == 1) begin mptr = int'(cmd_addr) / 4; mleft = int'(cmd_len) / 4; end
          else if (cmd_op == 2) begin mptr = ((int'(cmd_addr) / 4) / CH) * CH; mleft = CH; end
          else begin mptr = 0; mleft = DW; end
        end
        1: if (fire) mst = 3;
           else begin
             if (mleft == 1) begin mst = 0; mdone = 1; mlat = 0; end
             else if (mptr % CH == CH - 1 && irq_pend) mst = 2;
             mptr = (mptr + 1) % DW;
             mleft--;
           end
        2: if (fire) mst = 3; else if (!irq_pend) mst = 1;
        default: if (resume_req) begin mst = 1; mgap = RG; end
      endcase
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk("R5 busy", busy, mst != 0);
      chk("R5 done", done, mdone);
      chk("R5 irq_done", irq_done, mirq);
      chk("R9 cmd_err", cmd_err, merr);
      chk("R6 yielding", yielding, mst == 2);
      chk("R10 suspended", suspended, mst == 3);
      chk("R2 pdat_take", pdat_take, mst == 1 && mprog && mlat != 1);
      chk("R7 rd_ready", rd_ready, rd_en && rd_req && mst == 0);
      chk("R1 rd_data model", rd_data, mm[rd_addr]);
    end
    if (took) begin pidx++; took = 0; end
  end

  task automatic issue(input logic [1:0] op, input logic [7:0] a, input logic [9:0] len, input bit with_rd);
    @(negedge clk);
    rd_en = with_rd; cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_len = len;
    @(negedge clk);
    cmd_valid = 0; rd_en = 0;
  endtask

  task automatic expect_err(input string tag);
    #1;
    chk(tag, cmd_err, 1);
    chk(tag, busy, 0);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1; rd_req = 1; rd_addr = a[5:0];
    #1;
    chk(tag, rd_ready, 1);
    chk(tag, rd_data, exp);
    @(negedge clk);
    rd_en = 0; rd_req = 0;
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog: actual still running expected completion");
    finish_up();
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R12 busy after reset", busy, 0);
    chk("R12 irq after reset", irq_done, 0);
    rd_chk(0, 32'hFFFF_FFFF, "R12 erased word 0");
    rd_chk(63, 32'hFFFF_FFFF, "R12 erased word 63");

    // R7: no read without enable
    @(negedge clk); rd_req = 1; rd_en = 0; #1; chk("R7 no enable", rd_ready, 0);
    @(negedge clk); rd_req = 0;

    // R2: program two words, then AND-only update
    pbuf[0] = 32'hA5A5_0F0F; pbuf[1] = 32'h1234_5678; pidx = 0;
    issue(2'b01, 8'h10, 10'd8, 0); wait_idle();
    rd_chk(4, 32'hA5A5_0F0F, "R2 program word4");
    rd_chk(5, 32'h1234_5678, "R2 program word5");
    pbuf[0] = 32'hFFFF_0000; pidx = 0;
    issue(2'b01, 8'h10, 10'd4, 0); wait_idle();
    rd_chk(4, 32'hA5A5_0000, "R2 and update");
    pbuf[0] = 32'hFFFF_FFFF; pidx = 0;
    issue(2'b01, 8'h14, 10'd4, 0); wait_idle();
    rd_chk(5, 32'h1234_5678, "R2 zero stays zero");

    // R1: program across chunk edge, sector erase chunk 0
    pbuf[0] = 32'h0000_1111; pbuf[1] = 32'h2222_0000; pbuf[2] = 32'h3333_3333; pidx = 0;
    issue(2'b01, 8'h18, 10'd12, 0); wait_idle();
    rd_chk(8, 32'h3333_3333, "R2 crosses chunk");
    issue(2'b10, 8'h04, 10'd0, 0); wait_idle();
    rd_chk(4, 32'hFFFF_FFFF, "R1 sector erased word4");
    rd_chk(7, 32'hFFFF_FFFF, "R1 sector erased word7");
    rd_chk(8, 32'h3333_3333, "R1 next chunk kept");

    // R3, R4, R8: refused commands
    issue(2'b01, 8'h11, 10'd4, 0);  expect_err("R3 misaligned");
    issue(2'b00, 8'h20, 10'd4, 0);  expect_err("R3 bad op");
    issue(2'b01, 8'h20, 10'd0, 0);  expect_err("R4 zero length");
    issue(2'b01, 8'h20, 10'd6, 0);  expect_err("R4 odd length");
    issue(2'b01, 8'h00, 10'd260, 0); expect_err("R4 too long");
    issue(2'b11, 8'h00, 10'd0, 1);  expect_err("R8 read mode on");
    rd_chk(8, 32'h3333_3333, "R8 nothing erased");

    // R9: command while busy
    issue(2'b10, 8'h20, 10'd0, 0);
    pbuf[0] = 32'h0; pidx = 0;
    issue(2'b01, 8'h40, 10'd4, 0);
    #1; chk("R9 refused while busy", cmd_err, 1); chk("R9 still busy", busy, 1);
    @(negedge clk); rd_en = 1; rd_req = 1; #1; chk("R7 stalled while busy", rd_ready, 0);
    @(negedge clk); rd_en = 0; rd_req = 0;
    wait_idle();
    rd_chk(16, 32'hFFFF_FFFF, "R9 word16 untouched");

    // R5: chip erase duration, done, sticky irq
    issue(2'b11, 8'h00, 10'd0, 0);
    k = 0;
    while (busy && k < 500) begin @(negedge clk); k++; end
    #1;
    chk("R5 chip erase cycles", k, DW);
    chk("R5 done pulse", done, 1);
    rd_chk(8, 32'hFFFF_FFFF, "R1 chip erased");
    chk("R5 irq sticky", irq_done, 1);
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0; #1; chk("R5 irq cleared", irq_done, 0);

    // R6: yield at chunk end
    irq_pend = 1;
    issue(2'b11, 8'h00, 10'd0, 0);
    repeat (8) @(negedge clk);
    #1; chk("R6 yield at chunk end", yielding, 1);
    repeat (4) @(negedge clk);
    #1; chk("R6 still yielding", yielding, 1);
    irq_pend = 0;
    @(negedge clk); @(negedge clk);
    #1; chk("R6 resumed after irq", yielding, 0);
    wait_idle();

    // R10, R11: suspend latency and guard after resume
    issue(2'b11, 8'h00, 10'd0, 0);
    repeat (2) @(negedge clk);
    susp_req = 1; @(negedge clk); susp_req = 0;
    k = 1;
    while (!suspended && k < 100) begin @(negedge clk); k++; end
    chk("R10 suspend latency", k, SL + 1);
    repeat (5) @(negedge clk);
    #1; chk("R10 held suspended", suspended, 1);
    resume_req = 1; @(negedge clk); resume_req = 0;
    susp_req = 1; @(negedge clk); susp_req = 0;
    for (int i = 0; i < SL + 3; i++) begin
      @(negedge clk); #1; chk("R11 early suspend ignored", suspended, 0);
    end
    susp_req = 1; @(negedge clk); susp_req = 0;
    k = 1;
    while (!suspended && k < 100) begin @(negedge clk); k++; end
    chk("R10 later suspend honoured", k, SL + 1);
    resume_req = 1; @(negedge clk); resume_req = 0;
    wait_idle();
    rd_chk(63, 32'hFFFF_FFFF, "R10 erase completes");

    // R2: full page over all chunks with interrupt pauses
    for (int i = 0; i < 64; i++) pbuf[i] = (i * 32'h0101_0101) ^ 32'hF0F0_0000;
    pidx = 0; irq_pend = 1;
    issue(2'b01, 8'h00, 10'd256, 0);
    repeat (12) @(negedge clk); irq_pend = 0;
    repeat (10) @(negedge clk); irq_pend = 1;
    repeat (6) @(negedge clk); irq_pend = 0;
    wait_idle();
    rd_chk(0, 32'hF0F0_0000, "R2 page word0");
    rd_chk(31, (31 * 32'h0101_0101) ^ 32'hF0F0_0000, "R2 page word31");
    rd_chk(63, (63 * 32'h0101_0101) ^ 32'hF0F0_0000, "R2 page word63");

    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule